// File: doc/BRIEF.md
# Synchronous SRAM Read/Write Datapath with Dual-Cycle Deselect

This block is a clocked single-port memory of 36-bit words. Each word is built from four 9-bit byte lanes. The address, the write data and every command input are captured on the rising clock edge. A static mode input picks how read data reaches the output. In flow-through mode the word comes straight out of the array after the address register. In pipelined mode it passes through one more register clocked on the rising edge.

A deselect travels down the same stages as a read. In pipelined mode the output therefore keeps driving the previous read's word for one full cycle after a deselect is sampled. It stops only after the next rising edge.

Writes either update a chosen set of byte lanes or all four lanes at once. Output enable and sleep act on the output without waiting for the clock. Sleep also blocks every command, so the stored words are kept. The tri-state bus is modelled as a data output plus a drive flag. The data output reads zero whenever the drive flag is low.

Top module: `sram_dcd_top`

## Requirements
- R1: Flow-through mode (`pipeMode`=0): a read sampled at rising edge k drives `rdValid`=1 and the addressed word on `rdData` during the cycle that follows edge k.
- R2: Pipelined mode (`pipeMode`=1): a read sampled at rising edge k drives the addressed word during the cycle that follows edge k+1.
- R3: Dual-cycle deselect. A cycle with `chipSel`=0 is a deselect and moves through the same stages as a read. In pipelined mode, after a deselect at edge k that follows a read at edge k-1, the bus still drives the read's word until edge k+1. In flow-through mode the drive stops after edge k.
- R4: A byte write happens when `chipSel`=1, `byteWrEn`=1, `globalWr`=0 and `byteSel` is nonzero. Bit i of `byteSel` writes `wrData[9*i+8:9*i]` into the same bits of the word. Unselected lanes keep their old value.
- R5: A cycle with `chipSel`=1, `byteWrEn`=1, `byteSel`=0 and `globalWr`=0 is a read and leaves the array unchanged.
- R6: `globalWr`=1 with `chipSel`=1 writes all four lanes, whatever the values of `byteWrEn` and `byteSel`.
- R7: `outEn`=0 forces `rdValid` to 0 and `rdData` to 0 at once, with no clock edge needed. Raising `outEn` again brings back the pending word.
- R8: `sleep`=1 forces `rdValid` to 0 at once. Any read or write sampled while `sleep`=1 is ignored, and the array contents are kept.
- R9: A write produces no output beat. A read sampled at the edge after a write to the same word returns the newly written data.
- R10: After reset, `rdValid` is 0.
- R11: `rdData` is 0 whenever `rdValid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low reset of the control and output stages |
| pipeMode | input | 1 | Static read-mode select: 1 = pipelined, 0 = flow-through |
| chipSel | input | 1 | 1 = access (read or write), 0 = deselect |
| byteWrEn | input | 1 | Byte-write enable |
| byteSel | input | 4 | Per-lane write select |
| globalWr | input | 1 | Write all lanes |
| addr | input | $clog2(DEPTH) | Word address |
| wrData | input | 36 | Write data, 9 bits per lane |
| outEn | input | 1 | Asynchronous output enable |
| sleep | input | 1 | Asynchronous low-power input |
| rdData | output | 36 | Read data, 0 when not driving |
| rdValid | output | 1 | Bus-drive flag |

## Verification
Two activities can share a cycle and are exercised together. The first is a write landing in the array while an earlier read is still in the output stage. The second is a read that reaches a word in the same edge window in which that word was written. The bench issues writes directly behind reads, and reads directly behind writes to the same address. It does this in both modes and runs a full sweep of the byte-select patterns. Every cycle is compared with a bench model that tracks the array and the two-stage drive timing. The model takes a read's data from the array state at the moment the read is sampled. So a write arriving in the next cycle must not reach an earlier read's output, and a read that follows a write must see the new word.

// File: rtl/sram_dcd_pkg.sv
package sram_dcd_pkg;
  localparam int LANES   = 4;
  localparam int LANE_W  = 9;
  localparam int WORD_W  = LANES * LANE_W;

  // strobes passed from the control to the datapath each cycle
  typedef struct packed {
    logic [LANES-1:0] wrLanes;    // lanes written at this edge
    logic             rdLaunch;   // capture read address at this edge
    logic             outCapture; // load output register at this edge
  } sramStrobes_t;
endpackage

// File: rtl/sram_dcd_ctrl.sv
module sram_dcd_ctrl
  import sram_dcd_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             pipeMode,
  input  logic             chipSel,
  input  logic             byteWrEn,
  input  logic [LANES-1:0] byteSel,
  input  logic             globalWr,
  input  logic             outEn,
  input  logic             sleep,
  output sramStrobes_t     strobes,
  output logic             driveEn
);
  logic accept;
  logic isWrite;
  logic isRead;
  logic [LANES-1:0] laneMask;
  logic stage1Rd;
  logic stage2Rd;
  logic stageSel;

  // a command is taken only when selected and awake
  assign accept = chipSel & ~sleep;

  always_comb begin
    if (globalWr)
      laneMask = '1;
    else if (byteWrEn)
      laneMask = byteSel;
    else
      laneMask = '0;
  end

  assign isWrite = accept & (|laneMask);
  assign isRead  = accept & ~(|laneMask);

  // deselects and reads share these two stages
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1Rd <= 1'b0;
      stage2Rd <= 1'b0;
    end else begin
      stage1Rd <= isRead;
      stage2Rd <= stage1Rd;
    end
  end

  always_comb begin
    strobes            = '0;
    strobes.wrLanes    = isWrite ? laneMask : '0;
    strobes.rdLaunch   = isRead;
    strobes.outCapture = stage1Rd;
  end

  assign stageSel = pipeMode ? stage2Rd : stage1Rd;
  assign driveEn  = stageSel & outEn & ~sleep;

  // R8
  sleep_blocks_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    sleep |-> (strobes.wrLanes == '0));

  // R9
  rd_wr_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.rdLaunch, |strobes.wrLanes}));
endmodule

// File: rtl/sram_dcd_datapath.sv
module sram_dcd_datapath
  import sram_dcd_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pipeMode,
  input  logic [AW-1:0]     addr,
  input  logic [WORD_W-1:0] wrData,
  input  sramStrobes_t      strobes,
  input  logic              driveEn,
  output logic [WORD_W-1:0] rdData
);
  logic [AW-1:0]     rdAddr;
  logic [WORD_W-1:0] flowWord;
  logic [WORD_W-1:0] outReg;
  logic [WORD_W-1:0] selWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      rdAddr <= '0;
    else if (strobes.rdLaunch)
      rdAddr <= addr;
  end

  // one storage column per byte lane
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] laneMem [DEPTH];

    always_ff @(posedge clk) begin
      if (strobes.wrLanes[g])
        laneMem[addr] <= wrData[g*LANE_W +: LANE_W];
    end

    assign flowWord[g*LANE_W +: LANE_W] = laneMem[rdAddr];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      outReg <= '0;
    else if (strobes.outCapture)
      outReg <= flowWord;
  end

  assign selWord = pipeMode ? outReg : flowWord;
  assign rdData  = driveEn ? selWord : '0;

  // R2
  out_reg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobes.outCapture) |-> $stable(outReg));

  // R11
  idle_bus_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !driveEn |-> (rdData == '0));
endmodule

// File: rtl/sram_dcd_top.sv
module sram_dcd_top
  import sram_dcd_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pipeMode,
  input  logic              chipSel,
  input  logic              byteWrEn,
  input  logic [LANES-1:0]  byteSel,
  input  logic              globalWr,
  input  logic [AW-1:0]     addr,
  input  logic [WORD_W-1:0] wrData,
  input  logic              outEn,
  input  logic              sleep,
  output logic [WORD_W-1:0] rdData,
  output logic              rdValid
);
  sramStrobes_t strobes;
  logic         driveEn;

  sram_dcd_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .pipeMode (pipeMode),
    .chipSel  (chipSel),
    .byteWrEn (byteWrEn),
    .byteSel  (byteSel),
    .globalWr (globalWr),
    .outEn    (outEn),
    .sleep    (sleep),
    .strobes  (strobes),
    .driveEn  (driveEn)
  );

  sram_dcd_datapath #(.DEPTH(DEPTH)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .pipeMode (pipeMode),
    .addr     (addr),
    .wrData   (wrData),
    .strobes  (strobes),
    .driveEn  (driveEn),
    .rdData   (rdData)
  );

  assign rdValid = driveEn;

  // port-level view of the command, used only by the checks below
  logic portWrite;
  logic portRead;
  assign portWrite = chipSel & ~sleep & (globalWr | (byteWrEn & (|byteSel)));
  assign portRead  = chipSel & ~sleep & ~portWrite;

  // R1
  flow_read_drives_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!pipeMode && outEn && !sleep && $past(portRead)) |-> rdValid);

  // R2
  pipe_read_drives_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pipeMode && outEn && !sleep && $past(portRead, 2)) |-> rdValid);

  // R3
  pipe_deselect_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pipeMode && !$past(portRead, 2)) |-> !rdValid);

  // R7
  oe_sleep_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!outEn || sleep) |-> !rdValid);

  // R9
  write_no_beat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!pipeMode && $past(portWrite)) |-> !rdValid);
endmodule

// File: tb/sram_dcd_top_tb.sv
module sram_dcd_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 64;
  localparam int AW         = $clog2(DEPTH);
  localparam int WDOG       = 20000;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          pipeMode = 1'b1;
  logic          chipSel = 1'b0;
  logic          byteWrEn = 1'b0;
  logic [3:0]    byteSel = '0;
  logic          globalWr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [35:0]   wrData = '0;
  logic          outEn = 1'b1;
  logic          sleep = 1'b0;
  logic [35:0]   rdData;
  logic          rdValid;

  int checks = 0;
  int errors = 0;

  logic [35:0] bm [DEPTH];
  logic        m1v = 1'b0, m2v = 1'b0;
  logic [35:0] m1d = '0, m2d = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_dcd_top #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rstN(rstN), .pipeMode(pipeMode), .chipSel(chipSel),
    .byteWrEn(byteWrEn), .byteSel(byteSel), .globalWr(globalWr),
    .addr(addr), .wrData(wrData), .outEn(outEn), .sleep(sleep),
    .rdData(rdData), .rdValid(rdValid)
  );

  function automatic logic [35:0] pat(int a, int s);
    logic [63:0] p;
    p = 64'(a + 1) * 64'h0102_0409 + 64'(s) * 64'h5_A5A5_A5A5;
    return p[35:0];
  endfunction

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic check(string tag);
    logic        ev;
    logic [35:0] ed;
    ev = (pipeMode ? m2v : m1v) & outEn & ~sleep;
    ed = ev ? (pipeMode ? m2d : m1d) : 36'h0;
    checks++;
    if (rdValid !== ev || rdData !== ed) begin
      errors++;
      $display("FAIL %s: actual valid=%0b data=%h, expected valid=%0b data=%h",
               tag, rdValid, rdData, ev, ed);
    end
  endtask

  // apply one command, clock it, update the model, return at the negedge
  task automatic step(bit cs, bit bwe, logic [3:0] bs, bit gw, int a,
                      logic [35:0] wd);
    logic [3:0] lanes;
    logic       rd;
    chipSel = cs; byteWrEn = bwe; byteSel = bs; globalWr = gw;
    addr = AW'(a); wrData = wd;
    lanes = gw ? 4'hF : (bwe ? bs : 4'h0);
    rd = 1'b0;
    if (cs && !sleep) begin
      if (lanes != 0) begin
        for (int i = 0; i < 4; i++)
          if (lanes[i]) bm[a][9*i +: 9] = wd[9*i +: 9];
      end else begin
        rd = 1'b1;
      end
    end
    @(posedge clk);
    m2v = m1v; m2d = m1d;
    m1v = rd;  m1d = rd ? bm[a] : 36'h0;
    @(negedge clk);
  endtask

  task automatic rdTag(output string s);
    s = pipeMode ? "R2 pipelined read" : "R1 flow-through read";
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual run still busy, expected finished");
    summary();
    $finish;
  end

  initial begin
    string t;
    repeat (3) @(negedge clk);
    check("R10 reset output idle");
    rstN = 1'b1;
    @(negedge clk);
    check("R10 after reset release");

    for (int md = 0; md < 2; md++) begin
      pipeMode = md[0];
      step(0, 0, 0, 0, 0, 0);
      step(0, 0, 0, 0, 0, 0);
      rdTag(t);

      // R6 fill every word with a global write (byte controls scrambled)
      for (int a = 0; a < DEPTH; a++) begin
        step(1, a[0], 4'(a), 1, a, pat(a, md));
        check("R6 R9 global write, no beat");
      end
      // back-to-back read sweep
      for (int a = 0; a < DEPTH; a++) begin
        step(1, 0, 0, 0, a, 0);
        check(t);
      end
      // R3 dual-cycle deselect: one more beat in pipelined mode
      step(0, 0, 0, 0, 0, 0);
      check("R3 R11 first cycle after deselect");
      step(0, 0, 0, 0, 0, 0);
      check("R3 R11 second cycle after deselect");

      // R4/R5 byte-select sweep
      for (int bs = 0; bs < 16; bs++) begin
        step(1, 1, 4'(bs), 0, bs, ~pat(bs, 3));
        check(bs == 0 ? "R5 empty byte select acts as read" : "R4 byte write cycle");
        step(1, 0, 0, 0, bs, 0);
        check(bs == 0 ? "R5 word unchanged" : "R4 merged lanes");
        step(0, 0, 0, 0, 0, 0);
        check("R4 trailing beat");
      end
      // R6 global write wins with byte write enable off and no lanes
      step(1, 0, 4'h0, 1, 33, 36'h1_2345_6789);
      check("R6 global write");
      step(1, 0, 0, 0, 33, 0);
      check("R6 global readback");

      // R9 read directly behind write to same word, and write behind read
      for (int k = 0; k < 8; k++) begin
        step(1, 1, 4'(1 << (k % 4)), 0, 40 + k, pat(k, 7));
        check("R9 write cycle");
        step(1, 0, 0, 0, 40 + k, 0);
        check("R9 read after write");
        step(1, 0, 0, 1, 40 + k, pat(k, 9));
        check("R9 write behind read");
        step(0, 0, 0, 0, 0, 0);
        check("R9 old word for earlier read");
      end

      // R8 sleep: immediate off, commands ignored
      step(1, 0, 0, 0, 7, 0);
      step(1, 0, 0, 0, 8, 0);
      sleep = 1'b1;
      #1 check("R8 sleep drops bus at once");
      step(1, 0, 0, 1, 7, 36'hF_FFFF_FFFF);
      check("R8 write ignored while asleep");
      step(1, 0, 0, 0, 7, 0);
      check("R8 read ignored while asleep");
      sleep = 1'b0;
      #1 check("R8 wake");
      step(1, 0, 0, 0, 7, 0);
      check("R8 contents kept");
      step(0, 0, 0, 0, 0, 0);
      check("R8 contents kept beat");

      // R7 asynchronous output enable
      step(1, 0, 0, 0, 3, 0);
      step(0, 0, 0, 0, 0, 0);
      outEn = 1'b0;
      #1 check("R7 output enable low");
      outEn = 1'b1;
      #1 check("R7 output enable restored");
      step(0, 0, 0, 0, 0, 0);
      check("R7 R11 drained");
    end

    summary();
    $finish;
  end
endmodule